// File: doc/BRIEF.md
# Intersegment Line Push Unit

This per-core unit remembers which cache lines the current code segment produced for the segment that comes next, and later pushes those lines to the core that will run that next segment. A store retires carrying a producer tag. When it does, the unit drops the byte offset from the store's physical address. It then records the line address in a small ring, unless the ring already holds that line. The ring reports its occupancy at all times, so a runtime can estimate what a migration would cost before it starts one.

When the core issues the marshal command with a destination core number, a state machine walks the ring from the oldest entry to the newest. For each entry it makes one tag/state lookup in the local L2. Lines held exclusive or modified are offered one at a time on an outbound push port, with the destination attached, for delivery into the remote L2 fill buffer. Lines held shared or invalid are skipped. When the walk ends, a one-cycle done pulse is raised and the ring is emptied. New tagged retires are held off with a stall for the whole walk.

The walk machine has four states. W_IDLE goes to W_PROBE on a command when the ring is not empty, and goes to W_FINISH on a command when the ring is empty. W_PROBE goes to W_SEND on an acknowledged lookup that reports E or M. On an acknowledged lookup that reports I or S, it stays in W_PROBE if entries remain, or goes to W_FINISH if that entry was the last. W_SEND goes back to W_PROBE on an accepted push if entries remain, or goes to W_FINISH if that entry was the last. W_FINISH always returns to W_IDLE.

Top module: `line_push_unit`

## Requirements
- R1: A retire with `ret_valid` and `ret_gen` both high records `ret_paddr[PA_W-1:OFF_W]`, the line address without the low 6 offset bits. A retire with `ret_gen` low leaves the ring and `occupancy` unchanged.
- R2: A tagged retire whose line address is already in the ring is not added again, whatever its offset bits are, and `occupancy` does not change.
- R3: The ring holds 16 line addresses. When it is full, a new distinct line replaces the oldest entry, and `occupancy` stays at 16.
- R4: `occupancy` equals the number of distinct lines held. After reset it is 0, `ret_stall`, `lk_req`, `xf_valid` and `mar_done` are all low, and the unit is idle.
- R5: A command (`mcmd_valid` while idle) visits every held entry once, from oldest to newest. Each visit drives one `lk_req` cycle with `lk_addr` equal to the entry.
- R6: A line is offered on the push port only if `lk_state` is 2'b10 (exclusive) or 2'b11 (modified). The codes 2'b00 (invalid) and 2'b01 (shared) cause the entry to be skipped.
- R7: Every push carries the `mcmd_dest` value taken with the command. While `xf_ready` is low, `xf_valid`, `xf_addr` and `xf_dest` hold steady.
- R8: After the last entry has been handled, `mar_done` is high for exactly one cycle, and `occupancy` reads 0 in the following cycle. A command on an empty ring gives the done pulse with no lookup and no push.
- R9: `ret_stall` is high in the cycle a command is presented and throughout the walk. A tagged retire during that time is not recorded, and a second command during the walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A store retires this cycle |
| ret_gen | input | 1 | The retiring store carries the producer tag |
| ret_paddr | input | PA_W | Physical byte address written by the store |
| ret_stall | output | 1 | Tagged retires are held off |
| mcmd_valid | input | 1 | Marshal command |
| mcmd_dest | input | CORE_W | Destination core of the command |
| lk_req | output | 1 | Local L2 lookup request |
| lk_addr | output | PA_W-OFF_W | Line address being looked up |
| lk_ack | input | 1 | Lookup answered this cycle |
| lk_state | input | 2 | Coherence state of the looked-up line |
| xf_valid | output | 1 | Push request valid |
| xf_addr | output | PA_W-OFF_W | Line address to push |
| xf_dest | output | CORE_W | Destination core of the push |
| xf_ready | input | 1 | Push accepted |
| mar_done | output | 1 | One-cycle end-of-walk pulse |
| occupancy | output | $clog2(DEPTH+1) | Number of held lines |

## Verification
A broken merge or eviction in the ring shows up on `occupancy` in the cycle after the offending retire. It also shows up later as a wrong or reordered list of pushed addresses. A wrong walk index, count or state filter shows up during the next drain, as a missing, extra or out-of-order lookup or push. A clearing fault shows up one cycle after `mar_done`, because `occupancy` is not zero at that point. A missing stall lets a retire that arrives mid-walk change `occupancy` within one cycle, and the ports expose that directly.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_PROBE,
        W_SEND,
        W_FINISH
    } walk_state_t;

    localparam logic [1:0] CS_INV = 2'b00;
    localparam logic [1:0] CS_SHR = 2'b01;
    localparam logic [1:0] CS_EXC = 2'b10;
    localparam logic [1:0] CS_MOD = 2'b11;

    // Only a line this core owns outright may be pushed away.
    function automatic logic line_owned(input logic [1:0] cs);
        return (cs == CS_EXC) || (cs == CS_MOD);
    endfunction

endpackage

// File: rtl/lpu_addr_ring.sv
module lpu_addr_ring #(
    parameter  int LINE_W = 48,
    parameter  int DEPTH  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    output logic [IDX_W-1:0]  oldest_idx,
    output logic [CNT_W-1:0]  count
);

    logic [LINE_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0]  live;
    logic [DEPTH-1:0]  match;
    logic [IDX_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  wr_ptr_nx;
    logic [CNT_W-1:0]  fill;
    logic              full;
    logic              take;

    // Parallel compare of the incoming line against every live slot.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = live[g] && (slot[g] == ins_line);
        end
    endgenerate

    assign full      = (fill == CNT_W'(DEPTH));
    assign take      = ins_en && (match == '0) && !clr;
    assign wr_ptr_nx = (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live   <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            live   <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else if (take) begin
            live[wr_ptr] <= 1'b1;
            wr_ptr       <= wr_ptr_nx;
            if (!full) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // Address storage needs no reset; the live bits qualify it.
    always_ff @(posedge clk) begin
        if (take) begin
            slot[wr_ptr] <= ins_line;
        end
    end

    always_comb begin
        int unsigned base;
        base = int'(wr_ptr) + DEPTH - int'(fill);
        if (base >= DEPTH) begin
            base = base - DEPTH;
        end
        oldest_idx = IDX_W'(base);
    end

    assign rd_line = slot[rd_idx];
    assign count   = fill;

endmodule

// File: rtl/lpu_walk_fsm.sv
module lpu_walk_fsm
    import lpu_pkg::*;
#(
    parameter  int LINE_W = 48,
    parameter  int DEPTH  = 16,
    parameter  int CORE_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CORE_W-1:0] cmd_dest,
    input  logic [CNT_W-1:0]  count,
    input  logic [IDX_W-1:0]  oldest_idx,
    input  logic [LINE_W-1:0] rd_line,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              lk_ack,
    input  logic [1:0]        lk_state,
    input  logic              xf_ready,
    output logic              busy,
    output logic              lk_req,
    output logic [LINE_W-1:0] lk_addr,
    output logic              xf_valid,
    output logic [LINE_W-1:0] xf_addr,
    output logic [CORE_W-1:0] xf_dest,
    output logic              done,
    output logic              clr
);

    walk_state_t       st;
    walk_state_t       st_nx;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  left;
    logic [CORE_W-1:0] dest_q;
    logic [LINE_W-1:0] push_q;
    logic              last;
    logic              owned;

    assign last  = (left == CNT_W'(1));
    assign owned = line_owned(lk_state);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= W_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Transitions.
    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE: begin
                if (cmd_valid) begin
                    st_nx = (count == '0) ? W_FINISH : W_PROBE;
                end
            end
            W_PROBE: begin
                if (lk_ack) begin
                    if (owned) begin
                        st_nx = W_SEND;
                    end else if (last) begin
                        st_nx = W_FINISH;
                    end
                end
            end
            W_SEND: begin
                if (xf_ready) begin
                    st_nx = last ? W_FINISH : W_PROBE;
                end
            end
            W_FINISH: st_nx = W_IDLE;
            default:  st_nx = W_IDLE;
        endcase
    end

    // Walk bookkeeping: position, remaining entries, latched target.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            left   <= '0;
            dest_q <= '0;
            push_q <= '0;
        end else begin
            unique case (st)
                W_IDLE: begin
                    if (cmd_valid) begin
                        idx    <= oldest_idx;
                        left   <= count;
                        dest_q <= cmd_dest;
                    end
                end
                W_PROBE: begin
                    if (lk_ack) begin
                        if (owned) begin
                            push_q <= rd_line;
                        end else begin
                            idx  <= (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
                            left <= left - 1'b1;
                        end
                    end
                end
                W_SEND: begin
                    if (xf_ready) begin
                        idx  <= (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
                        left <= left - 1'b1;
                    end
                end
                W_FINISH: left <= '0;
                default:  left <= '0;
            endcase
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        busy     = 1'b0;
        lk_req   = 1'b0;
        xf_valid = 1'b0;
        done     = 1'b0;
        clr      = 1'b0;
        unique case (st)
            W_IDLE:   busy = 1'b0;
            W_PROBE: begin
                busy   = 1'b1;
                lk_req = 1'b1;
            end
            W_SEND: begin
                busy     = 1'b1;
                xf_valid = 1'b1;
            end
            W_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
                clr  = 1'b1;
            end
            default:  busy = 1'b0;
        endcase
    end

    assign rd_idx  = idx;
    assign lk_addr = rd_line;
    assign xf_addr = push_q;
    assign xf_dest = dest_q;

endmodule

// File: rtl/line_push_unit.sv
module line_push_unit #(
    parameter  int PA_W   = 54,
    parameter  int OFF_W  = 6,
    parameter  int DEPTH  = 16,
    parameter  int CORE_W = 4,
    localparam int LINE_W = PA_W - OFF_W,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_gen,
    input  logic [PA_W-1:0]   ret_paddr,
    output logic              ret_stall,
    input  logic              mcmd_valid,
    input  logic [CORE_W-1:0] mcmd_dest,
    output logic              lk_req,
    output logic [LINE_W-1:0] lk_addr,
    input  logic              lk_ack,
    input  logic [1:0]        lk_state,
    output logic              xf_valid,
    output logic [LINE_W-1:0] xf_addr,
    output logic [CORE_W-1:0] xf_dest,
    input  logic              xf_ready,
    output logic              mar_done,
    output logic [CNT_W-1:0]  occupancy
);

    logic              busy;
    logic              clr;
    logic              ins_en;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  oldest_idx;
    logic [LINE_W-1:0] rd_line;

    // A command in the same cycle also freezes the ring, so the walk
    // sees exactly the contents present when it was requested.
    assign ret_stall = busy || mcmd_valid;
    assign ins_en    = ret_valid && ret_gen && !ret_stall;

    lpu_addr_ring #(
        .LINE_W (LINE_W),
        .DEPTH  (DEPTH)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (ins_en),
        .ins_line   (ret_paddr[PA_W-1:OFF_W]),
        .clr        (clr),
        .rd_idx     (rd_idx),
        .rd_line    (rd_line),
        .oldest_idx (oldest_idx),
        .count      (occupancy)
    );

    lpu_walk_fsm #(
        .LINE_W (LINE_W),
        .DEPTH  (DEPTH),
        .CORE_W (CORE_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (mcmd_valid),
        .cmd_dest   (mcmd_dest),
        .count      (occupancy),
        .oldest_idx (oldest_idx),
        .rd_line    (rd_line),
        .rd_idx     (rd_idx),
        .lk_ack     (lk_ack),
        .lk_state   (lk_state),
        .xf_ready   (xf_ready),
        .busy       (busy),
        .lk_req     (lk_req),
        .lk_addr    (lk_addr),
        .xf_valid   (xf_valid),
        .xf_addr    (xf_addr),
        .xf_dest    (xf_dest),
        .done       (mar_done),
        .clr        (clr)
    );

endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
    parameter  int PA_W   = 54,
    parameter  int OFF_W  = 6,
    parameter  int DEPTH  = 16,
    parameter  int CORE_W = 4,
    localparam int LINE_W = PA_W - OFF_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic              ret_gen,
    input logic [PA_W-1:0]   ret_paddr,
    input logic              ret_stall,
    input logic              lk_req,
    input logic              lk_ack,
    input logic [1:0]        lk_state,
    input logic              xf_valid,
    input logic [LINE_W-1:0] xf_addr,
    input logic [CORE_W-1:0] xf_dest,
    input logic              xf_ready,
    input logic              mar_done,
    input logic [CNT_W-1:0]  occupancy
);

    assert_line_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_gen) |-> !$isunknown(ret_paddr));

    assert_occ_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_done |=> ({1'b0, occupancy} <= ({1'b0, $past(occupancy)} + (CNT_W+1)'(1))));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    assert_push_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xf_valid) |-> ($past(lk_req) && $past(lk_ack) && $past(lk_state[1])));

    assert_push_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xf_valid && !xf_ready) |=> (xf_valid && $stable(xf_addr) && $stable(xf_dest)));

    assert_clear_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mar_done |=> (occupancy == '0));

    assert_stall_in_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req || xf_valid || mar_done) |-> ret_stall);

    assert_frozen_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> $stable(occupancy));

endmodule

bind line_push_unit lpu_checker #(
    .PA_W   (PA_W),
    .OFF_W  (OFF_W),
    .DEPTH  (DEPTH),
    .CORE_W (CORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_gen   (ret_gen),
    .ret_paddr (ret_paddr),
    .ret_stall (ret_stall),
    .lk_req    (lk_req),
    .lk_ack    (lk_ack),
    .lk_state  (lk_state),
    .xf_valid  (xf_valid),
    .xf_addr   (xf_addr),
    .xf_dest   (xf_dest),
    .xf_ready  (xf_ready),
    .mar_done  (mar_done),
    .occupancy (occupancy)
);

// File: tb/line_push_unit_bench.sv
module line_push_unit_bench;

    localparam int PA_W = 54;
    localparam int OFF_W = 6;
    localparam int DEPTH = 16;
    localparam int CORE_W = 4;
    localparam int LINE_W = PA_W - OFF_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    // {tagged, line[47:0], offset[5:0], expected occupancy[4:0]}
    // The low two line bits give the L2 state the mock returns.
    localparam logic [59:0] VEC [8] = '{
        {1'b1, 48'hA0, 6'h05, 5'd1},  // R1 invalid line recorded
        {1'b1, 48'hA3, 6'h3F, 5'd2},  // R1 modified line
        {1'b0, 48'hB2, 6'h00, 5'd2},  // R1 untagged ignored
        {1'b1, 48'hA0, 6'h3A, 5'd2},  // R2 duplicate, other offset
        {1'b1, 48'hC2, 6'h11, 5'd3},  // exclusive line
        {1'b1, 48'hC5, 6'h00, 5'd4},  // shared line
        {1'b1, 48'hA3, 6'h01, 5'd4},  // R2 duplicate
        {1'b1, 48'hD7, 6'h2C, 5'd5}   // modified line
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ret_valid = 1'b0;
    logic              ret_gen = 1'b0;
    logic [PA_W-1:0]   ret_paddr = '0;
    logic              ret_stall;
    logic              mcmd_valid = 1'b0;
    logic [CORE_W-1:0] mcmd_dest = '0;
    logic              lk_req;
    logic [LINE_W-1:0] lk_addr;
    logic              lk_ack;
    logic [1:0]        lk_state;
    logic              xf_valid;
    logic [LINE_W-1:0] xf_addr;
    logic [CORE_W-1:0] xf_dest;
    logic              xf_ready;
    logic              mar_done;
    logic [CNT_W-1:0]  occupancy;

    logic [31:0] cyc = '0;
    logic        rdy_all = 1'b1;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          lk_cnt = 0;
    logic [LINE_W-1:0] mdl [$];
    logic [LINE_W-1:0] got_a [$];
    logic [CORE_W-1:0] got_d [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Mock L2 answers at once; mock fabric is ready on odd cycles or always.
    assign lk_ack   = lk_req;
    assign lk_state = lk_addr[1:0];
    assign xf_ready = rdy_all | cyc[0];

    line_push_unit u_line_push_unit (
        .clk (clk), .rst_n (rst_n),
        .ret_valid (ret_valid), .ret_gen (ret_gen), .ret_paddr (ret_paddr),
        .ret_stall (ret_stall),
        .mcmd_valid (mcmd_valid), .mcmd_dest (mcmd_dest),
        .lk_req (lk_req), .lk_addr (lk_addr), .lk_ack (lk_ack), .lk_state (lk_state),
        .xf_valid (xf_valid), .xf_addr (xf_addr), .xf_dest (xf_dest), .xf_ready (xf_ready),
        .mar_done (mar_done), .occupancy (occupancy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (lk_req) lk_cnt++;
            if (xf_valid && xf_ready) begin
                got_a.push_back(xf_addr);
                got_d.push_back(xf_dest);
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic mdl_ins(input logic [LINE_W-1:0] ln);
        bit seen = 0;
        foreach (mdl[i]) if (mdl[i] == ln) seen = 1;
        if (!seen) begin
            if (mdl.size() == DEPTH) void'(mdl.pop_front());
            mdl.push_back(ln);
        end
    endtask

    task automatic retire(input bit g, input logic [LINE_W-1:0] ln, input logic [OFF_W-1:0] off);
        @(negedge clk);
        ret_valid = 1'b1;
        ret_gen   = g;
        ret_paddr = {ln, off};
        @(negedge clk);
        ret_valid = 1'b0;
        ret_gen   = 1'b0;
        if (g) mdl_ins(ln);
    endtask

    // Issue a command and compare the whole walk with the model.
    task automatic marshal(input logic [CORE_W-1:0] dst, input bit poke);
        logic [LINE_W-1:0] exp_a [$];
        int n_ent;
        int waited;
        logic [CNT_W-1:0] occ_before;
        foreach (mdl[i]) if (mdl[i][1]) exp_a.push_back(mdl[i]);
        n_ent = mdl.size();
        got_a.delete();
        got_d.delete();
        lk_cnt = 0;
        occ_before = occupancy;
        @(negedge clk);
        mcmd_valid = 1'b1;
        mcmd_dest  = dst;
        #1 chk(ret_stall == 1'b1, "R9 stall with command", 64'(ret_stall), 64'd1);
        @(negedge clk);
        mcmd_valid = 1'b0;
        if (poke && !mar_done) begin
            ret_valid  = 1'b1;
            ret_gen    = 1'b1;
            ret_paddr  = {48'hE3, 6'h00};
            mcmd_valid = 1'b1;
            mcmd_dest  = dst ^ 4'hF;
            #1 chk(ret_stall == 1'b1, "R9 stall in walk", 64'(ret_stall), 64'd1);
            @(negedge clk);
            ret_valid  = 1'b0;
            ret_gen    = 1'b0;
            mcmd_valid = 1'b0;
            chk(occupancy == occ_before || mar_done, "R9 retire held off", 64'(occupancy), 64'(occ_before));
        end
        waited = 0;
        while (!mar_done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(mar_done == 1'b1, "R8 done raised", 64'(mar_done), 64'd1);
        chk(lk_cnt == n_ent, "R5 one lookup per entry", 64'(lk_cnt), 64'(n_ent));
        chk(got_a.size() == exp_a.size(), "R6 push count", 64'(got_a.size()), 64'(exp_a.size()));
        for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
            chk(got_a[i] == exp_a[i], "R5 push order", 64'(got_a[i]), 64'(exp_a[i]));
            chk(got_d[i] == dst, "R7 push destination", 64'(got_d[i]), 64'(dst));
        end
        @(negedge clk);
        chk(mar_done == 1'b0, "R8 done one cycle", 64'(mar_done), 64'd0);
        chk(occupancy == '0, "R8 ring cleared", 64'(occupancy), 64'd0);
        mdl.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state
        chk(occupancy == '0, "R4 reset occupancy", 64'(occupancy), 64'd0);
        chk({ret_stall, lk_req, xf_valid, mar_done} == 4'b0, "R4 reset outputs",
            64'({ret_stall, lk_req, xf_valid, mar_done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: recording, line stripping, merging.
        for (int i = 0; i < 8; i++) begin
            logic [59:0] v;
            v = VEC[i];
            retire(v[59], v[58:11], v[10:5]);
            chk(occupancy == v[CNT_W-1:0], "R1/R2 occupancy after retire", 64'(occupancy), 64'(v[4:0]));
            chk(int'(occupancy) == mdl.size(), "R4 occupancy matches held lines", 64'(occupancy), 64'(mdl.size()));
        end

        // Drain with back-pressure, a stalled retire and an ignored command.
        rdy_all = 1'b0;
        marshal(4'h9, 1'b1);
        rdy_all = 1'b1;

        // R3: overflow replaces the oldest lines.
        for (int i = 0; i < 20; i++) begin
            retire(1'b1, LINE_W'({i, 2'b11}), 6'(i));
        end
        chk(occupancy == CNT_W'(DEPTH), "R3 full occupancy", 64'(occupancy), 64'(DEPTH));
        retire(1'b1, LINE_W'(3), 6'h0);
        chk(occupancy == CNT_W'(DEPTH), "R3 evicted line is new again", 64'(occupancy), 64'(DEPTH));
        retire(1'b1, LINE_W'({32'd19, 2'b11}), 6'h2);
        chk(occupancy == CNT_W'(DEPTH), "R2 merge while full", 64'(occupancy), 64'(DEPTH));
        marshal(4'h3, 1'b0);

        // R8/R9: empty walk with a tagged retire in the command cycle.
        @(negedge clk);
        ret_valid  = 1'b1;
        ret_gen    = 1'b1;
        ret_paddr  = {48'h77, 6'h00};
        mcmd_valid = 1'b1;
        mcmd_dest  = 4'h6;
        lk_cnt = 0;
        got_a.delete();
        #1 chk(ret_stall == 1'b1, "R9 stall on command cycle", 64'(ret_stall), 64'd1);
        @(negedge clk);
        ret_valid  = 1'b0;
        ret_gen    = 1'b0;
        mcmd_valid = 1'b0;
        chk(mar_done == 1'b1, "R8 empty walk done", 64'(mar_done), 64'd1);
        @(negedge clk);
        chk(lk_cnt == 0 && got_a.size() == 0, "R8 empty walk no traffic", 64'(lk_cnt), 64'd0);
        chk(occupancy == '0, "R9 command-cycle retire dropped", 64'(occupancy), 64'd0);

        // Untagged-only traffic then a single exclusive line.
        retire(1'b0, 48'h1F2, 6'h00);
        chk(occupancy == '0, "R1 untagged ignored", 64'(occupancy), 64'd0);
        retire(1'b1, 48'h1F2, 6'h3F);
        marshal(4'hC, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule